// File: doc/BRIEF.md
# Vectored Interrupt Request Unit

This unit sits beside an instruction sequencer and turns posted interrupt numbers into program-counter redirects. An external device or a software instruction posts a request by writing a small interrupt number into a pending register. Number zero means "no request", and writing it changes nothing. After every instruction the sequencer pulses `instr_end`. The unit then inserts one check cycle, shown on `chk_stall`, in which the core waits. This cycle is spent whether or not anything is pending.

In the check cycle, if a number is pending and no handler is running, the unit reads the handler address for that number from an eight-entry vector table. It saves the PC that the core presented with `instr_end`, and issues a one-cycle redirect to the handler. When the handler ends, the core pulses `ret_strobe`, and the unit redirects back to the saved PC. Handlers do not nest. The vector table is loaded through a simple configuration write port.

When a software request and a device request are written in the same cycle, the software number becomes pending. The device number is parked and becomes pending at the next dispatch, so it is serviced at a later check cycle.

Top module: `irq_vector_unit`

## Requirements
- R1: After synchronous reset, `chk_stall`, `redir_valid` and `in_handler` are 0 and no request is pending.
- R2: Every `instr_end` pulse seen outside a check cycle makes `chk_stall` high for exactly the next cycle, whether or not a request is pending. An `instr_end` during a check cycle is ignored.
- R3: A write with a nonzero number (`ext_num` or `sw_num`, 3 bits, values 1..7) makes that number pending. A write of number 0 is ignored and causes no dispatch.
- R4: In a check cycle with a request pending and no handler active, the next cycle shows `redir_valid`=1 for one cycle, with `redir_pc` equal to the table entry indexed by the pending number, and `in_handler`=1. The pending request is consumed.
- R5: When the software and device ports both write nonzero numbers in one cycle, the software number is dispatched at the next check cycle. The device number is dispatched at the check cycle after that, unless a newer write replaces it.
- R6: The PC saved at dispatch is the `cur_pc` presented with the `instr_end` that opened that check cycle. A `ret_strobe` while `in_handler`=1 produces `redir_valid`=1 with `redir_pc` equal to that saved PC, and clears `in_handler`.
- R7: While `in_handler`=1, check cycles do not dispatch, and a pending request stays pending until a check cycle after the return.
- R8: A configuration write of `cfg_data` to entry `cfg_addr` replaces that table entry, and later dispatches of that number use the new address.
- R9: A `ret_strobe` while `in_handler`=0 is ignored, and no redirect follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_end | input | 1 | Pulse at the end of each instruction |
| cur_pc | input | 8 | PC to resume at, valid with `instr_end` |
| ext_we | input | 1 | Device request write strobe |
| ext_num | input | 3 | Device interrupt number, 0 = none |
| sw_we | input | 1 | Software request write strobe |
| sw_num | input | 3 | Software interrupt number, 0 = none |
| ret_strobe | input | 1 | Handler finished, restore saved PC |
| cfg_we | input | 1 | Vector table write strobe |
| cfg_addr | input | 3 | Vector table entry to write |
| cfg_data | input | 8 | Handler address to store |
| chk_stall | output | 1 | High during the inserted check cycle |
| redir_valid | output | 1 | One-cycle PC redirect request |
| redir_pc | output | 8 | Redirect target, valid with `redir_valid` |
| in_handler | output | 1 | A handler is running |

## Verification
The assertions check the cycle-level rules on every clock:
- the check cycle lasts exactly one cycle and follows each accepted `instr_end`;
- a dispatch yields a redirect to the table value;
- a return yields the saved PC;
- no redirect occurs inside a handler except on return;
- a write lands in the pending register, with software winning a collision.

Only the bench scenarios can show the longer-range properties: a parked device request is served one dispatch later, a request posted during a handler survives the return, a reprogrammed table entry takes effect, and the saved PC is the one from the opening `instr_end` rather than from later instructions.

// File: rtl/irq_vec_pkg.sv
`timescale 1ns/1ps
package irq_vec_pkg;
  // Which port fed the pending register in a given cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DEV  = 2'd1,
    SRC_SW   = 2'd2,
    SRC_BOTH = 2'd3
  } req_src_e;

  function automatic req_src_e classify(input logic dev_ok, input logic sw_ok);
    return req_src_e'({sw_ok, dev_ok});
  endfunction
endpackage

// File: rtl/irq_vec_table.sv
`timescale 1ns/1ps
module irq_vec_table #(
  parameter int ENTRIES = 8,
  parameter int VEC_W   = 8,
  parameter int NUM_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [NUM_W-1:0] waddr,
  input  logic [VEC_W-1:0] wdata,
  input  logic [NUM_W-1:0] raddr,
  output logic [VEC_W-1:0] rdata
);
  // Small distributed RAM: write on the clock, asynchronous read.
  // A same-cycle write lands after the edge, so a read returns the old value.
  logic [VEC_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/irq_pend.sv
`timescale 1ns/1ps
module irq_pend
  import irq_vec_pkg::*;
#(
  parameter int NUM_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_we,
  input  logic [NUM_W-1:0] ext_num,
  input  logic             sw_we,
  input  logic [NUM_W-1:0] sw_num,
  input  logic             take,
  output logic             pend_v,
  output logic [NUM_W-1:0] pend_n
);
  logic             dev_ok, sw_ok;
  logic             park_v;
  logic [NUM_W-1:0] park_n;
  req_src_e         src;

  assign dev_ok = ext_we && (ext_num != '0);
  assign sw_ok  = sw_we  && (sw_num  != '0);
  assign src    = classify(dev_ok, sw_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend_n <= '0;
      park_v <= 1'b0;
      park_n <= '0;
    end else begin
      unique case (src)
        SRC_BOTH: begin
          pend_v <= 1'b1;
          pend_n <= sw_num;
          park_v <= 1'b1;
          park_n <= ext_num;
        end
        SRC_SW: begin
          pend_v <= 1'b1;
          pend_n <= sw_num;
        end
        SRC_DEV: begin
          pend_v <= 1'b1;
          pend_n <= ext_num;
        end
        default: begin
          if (take) begin
            // Consumed: a parked device request moves up
            pend_v <= park_v;
            pend_n <= park_n;
            park_v <= 1'b0;
          end
        end
      endcase
    end
  end

  AST_SW_WINS: assert property (@(posedge clk) disable iff (rst)
    sw_ok |=> (pend_v && pend_n == $past(sw_num))); // R5
  AST_DEV_POSTS: assert property (@(posedge clk) disable iff (rst)
    (dev_ok && !sw_ok) |=> (pend_v && pend_n == $past(ext_num))); // R3
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!dev_ok && !sw_ok && !take) |=> ($stable(pend_v) && $stable(pend_n))); // R3
endmodule

// File: rtl/irq_seq.sv
`timescale 1ns/1ps
module irq_seq #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_end,
  input  logic [VEC_W-1:0] cur_pc,
  input  logic             ret_strobe,
  input  logic             pend_v,
  input  logic [VEC_W-1:0] vec,
  output logic             take,
  output logic             chk_stall,
  output logic             redir_valid,
  output logic [VEC_W-1:0] redir_pc,
  output logic             in_handler
);
  logic [VEC_W-1:0] resume_pc;
  logic [VEC_W-1:0] saved_pc;
  logic             ret_ok;
  logic             end_ok;

  assign end_ok = instr_end && !chk_stall;
  assign take   = chk_stall && pend_v && !in_handler;
  assign ret_ok = ret_strobe && in_handler;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_stall   <= 1'b0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      in_handler  <= 1'b0;
      resume_pc   <= '0;
      saved_pc    <= '0;
    end else begin
      chk_stall   <= end_ok;
      redir_valid <= take || ret_ok;
      if (end_ok) resume_pc <= cur_pc;
      if (take) begin
        redir_pc   <= vec;
        saved_pc   <= resume_pc;
        in_handler <= 1'b1;
      end else if (ret_ok) begin
        redir_pc   <= saved_pc;
        in_handler <= 1'b0;
      end
    end
  end

  AST_CHECK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    chk_stall |=> !chk_stall); // R2
  AST_CHECK_FOLLOWS_END: assert property (@(posedge clk) disable iff (rst)
    (instr_end && !chk_stall) |=> chk_stall); // R2
  AST_DISPATCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    take |=> (redir_valid && in_handler && redir_pc == $past(vec))); // R4
  AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (rst)
    (ret_strobe && in_handler) |=> (redir_valid && !in_handler && redir_pc == $past(saved_pc))); // R6
  AST_NO_NESTING: assert property (@(posedge clk) disable iff (rst)
    (in_handler && !ret_strobe) |=> !redir_valid); // R7
  AST_STRAY_RETURN: assert property (@(posedge clk) disable iff (rst)
    (!in_handler && !(chk_stall && pend_v)) |=> !redir_valid); // R9
endmodule

// File: rtl/irq_vector_unit.sv
`timescale 1ns/1ps
module irq_vector_unit #(
  parameter int ENTRIES = 8,
  parameter int VEC_W   = 8,
  parameter int NUM_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_end,
  input  logic [VEC_W-1:0] cur_pc,
  input  logic             ext_we,
  input  logic [NUM_W-1:0] ext_num,
  input  logic             sw_we,
  input  logic [NUM_W-1:0] sw_num,
  input  logic             ret_strobe,
  input  logic             cfg_we,
  input  logic [NUM_W-1:0] cfg_addr,
  input  logic [VEC_W-1:0] cfg_data,
  output logic             chk_stall,
  output logic             redir_valid,
  output logic [VEC_W-1:0] redir_pc,
  output logic             in_handler
);
  logic             pend_v;
  logic [NUM_W-1:0] pend_n;
  logic [VEC_W-1:0] vec;
  logic             take;

  irq_vec_table #(.ENTRIES(ENTRIES), .VEC_W(VEC_W), .NUM_W(NUM_W)) u_table (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata (cfg_data),
    .raddr (pend_n),
    .rdata (vec)
  );

  irq_pend #(.NUM_W(NUM_W)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .ext_we  (ext_we),
    .ext_num (ext_num),
    .sw_we   (sw_we),
    .sw_num  (sw_num),
    .take    (take),
    .pend_v  (pend_v),
    .pend_n  (pend_n)
  );

  irq_seq #(.VEC_W(VEC_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .instr_end   (instr_end),
    .cur_pc      (cur_pc),
    .ret_strobe  (ret_strobe),
    .pend_v      (pend_v),
    .vec         (vec),
    .take        (take),
    .chk_stall   (chk_stall),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .in_handler  (in_handler)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!chk_stall && !redir_valid && !in_handler)); // R1
endmodule

// File: tb/test_irq_vector_unit.sv
`timescale 1ns/1ps
module test_irq_vector_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       instr_end = 1'b0;
  logic [7:0] cur_pc = '0;
  logic       ext_we = 1'b0;
  logic [2:0] ext_num = '0;
  logic       sw_we = 1'b0;
  logic [2:0] sw_num = '0;
  logic       ret_strobe = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic       chk_stall, redir_valid, in_handler;
  logic [7:0] redir_pc;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_vector_unit i_irq_vector_unit (
    .clk(clk), .rst(rst), .instr_end(instr_end), .cur_pc(cur_pc),
    .ext_we(ext_we), .ext_num(ext_num), .sw_we(sw_we), .sw_num(sw_num),
    .ret_strobe(ret_strobe), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .chk_stall(chk_stall), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .in_handler(in_handler)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, updated on each rising edge
  int m_chk, m_pv, m_pn, m_hv, m_hn, m_busy, m_rv, m_rpc, m_saved, m_cand;
  int m_tbl [8];
  initial begin
    foreach (m_tbl[i]) m_tbl[i] = 0;
  end

  always @(posedge clk) begin
    int disp, retk, swok, exok, vecv;
    if (rst) begin
      m_chk = 0; m_pv = 0; m_pn = 0; m_hv = 0; m_hn = 0;
      m_busy = 0; m_rv = 0; m_rpc = 0; m_saved = 0; m_cand = 0;
    end else begin
      disp = (m_chk != 0 && m_pv != 0 && m_busy == 0) ? 1 : 0;
      retk = (ret_strobe && m_busy != 0) ? 1 : 0;
      swok = (sw_we && sw_num != 0) ? 1 : 0;
      exok = (ext_we && ext_num != 0) ? 1 : 0;
      vecv = m_tbl[m_pn];
      m_rv = disp | retk;
      if (disp != 0) begin
        m_rpc = vecv; m_saved = m_cand; m_busy = 1;
      end else if (retk != 0) begin
        m_rpc = m_saved; m_busy = 0;
      end
      if (instr_end && m_chk == 0) m_cand = cur_pc;
      m_chk = (instr_end && m_chk == 0) ? 1 : 0;
      if (swok != 0) begin
        m_pv = 1; m_pn = sw_num;
        if (exok != 0) begin m_hv = 1; m_hn = ext_num; end
      end else if (exok != 0) begin
        m_pv = 1; m_pn = ext_num;
      end else if (disp != 0) begin
        m_pv = m_hv; m_pn = m_hn; m_hv = 0;
      end
      if (cfg_we) m_tbl[cfg_addr] = cfg_data;
    end
  end

  // Compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 chk_stall vs model", chk_stall, m_chk);
      check("R7 in_handler vs model", in_handler, m_busy);
      check("R4 redir_valid vs model", redir_valid, m_rv);
      if (redir_valid) check("R4 redir_pc vs model", redir_pc, m_rpc);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  // Ends one instruction; returns one cycle after the check cycle
  task automatic run_instr(input logic [7:0] pc);
    instr_end = 1'b1; cur_pc = pc;
    tick();
    instr_end = 1'b0;
    check("R2 check cycle after instr_end", chk_stall, 1);
    tick();
  endtask

  task automatic post_dev(input logic [2:0] n);
    ext_we = 1'b1; ext_num = n; tick(); ext_we = 1'b0;
  endtask

  task automatic post_sw(input logic [2:0] n);
    sw_we = 1'b1; sw_num = n; tick(); sw_we = 1'b0;
  endtask

  task automatic do_return();
    ret_strobe = 1'b1; tick(); ret_strobe = 1'b0;
  endtask

  task automatic watch_redirect(input string req, input int v, input int pc);
    check(req, redir_valid, v);
    if (v != 0) check(req, redir_pc, pc);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    n_checks++; n_fail++;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : stim
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check("R1 chk_stall after reset", chk_stall, 0);
    check("R1 redir_valid after reset", redir_valid, 0);
    check("R1 in_handler after reset", in_handler, 0);

    for (int i = 0; i < 8; i++) begin
      cfg_we = 1'b1; cfg_addr = 3'(i); cfg_data = 8'(i * 16 + 3);
      tick();
    end
    cfg_we = 1'b0;

    // R2: the check cycle is spent with nothing pending
    run_instr(8'h01);
    watch_redirect("R2 idle check no redirect", 0, 0);
    // R2: instr_end held high across the check cycle is only taken once
    instr_end = 1'b1; tick(); tick(); instr_end = 1'b0;
    check("R2 instr_end during check ignored", chk_stall, 0);

    // R3: number zero is ignored
    post_dev(3'd0);
    run_instr(8'h02);
    watch_redirect("R3 zero write no dispatch", 0, 0);

    // R4 / R6: dispatch of device number 5
    post_dev(3'd5);
    run_instr(8'h42);
    watch_redirect("R4 dispatch to entry 5", 1, 8'h53);
    check("R4 in_handler set", in_handler, 1);
    tick();
    check("R4 redirect is one pulse", redir_valid, 0);

    // R7: a request during a handler waits
    post_sw(3'd2);
    run_instr(8'h77);
    watch_redirect("R7 no dispatch inside handler", 0, 0);
    do_return();
    watch_redirect("R6 return to saved pc", 1, 8'h42);
    check("R6 in_handler cleared", in_handler, 0);
    run_instr(8'h44);
    watch_redirect("R7 held request dispatched", 1, 8'h23);
    do_return();
    watch_redirect("R6 second return", 1, 8'h44);

    // R9: stray return
    tick();
    do_return();
    watch_redirect("R9 stray return ignored", 0, 0);
    check("R9 in_handler stays low", in_handler, 0);

    // R5: collision, software first then parked device
    sw_we = 1'b1; sw_num = 3'd6; ext_we = 1'b1; ext_num = 3'd3;
    tick();
    sw_we = 1'b0; ext_we = 1'b0;
    run_instr(8'h10);
    watch_redirect("R5 software wins", 1, 8'h63);
    do_return();
    watch_redirect("R5 return", 1, 8'h10);
    run_instr(8'h11);
    watch_redirect("R5 parked device next", 1, 8'h33);
    do_return();

    // R8: reprogram an entry
    cfg_we = 1'b1; cfg_addr = 3'd4; cfg_data = 8'hA5; tick(); cfg_we = 1'b0;
    post_dev(3'd4);
    run_instr(8'h20);
    watch_redirect("R8 new table entry used", 1, 8'hA5);
    do_return();

    // Mixed traffic, compared to the model every cycle
    for (int c = 0; c < 3000; c++) begin
      instr_end  = ($urandom_range(0, 9) < 3);
      cur_pc     = 8'($urandom);
      ext_we     = ($urandom_range(0, 19) < 3);
      ext_num    = 3'($urandom);
      sw_we      = ($urandom_range(0, 9) == 0);
      sw_num     = 3'($urandom);
      ret_strobe = ($urandom_range(0, 9) == 0);
      cfg_we     = ($urandom_range(0, 19) == 0);
      cfg_addr   = 3'($urandom);
      cfg_data   = 8'($urandom);
      tick();
    end
    instr_end = 0; ext_we = 0; sw_we = 0; ret_strobe = 0; cfg_we = 0;
    tick();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule